// File: doc/BRIEF.md
# Software-Controlled Bus Lock Register

This block is a 32-bit supervisor control register. Software uses it to drive two bus lock pins, a lock pin and a lock-end pin, while it emulates atomic read-modify-write sequences in software. Software reads and writes the register through a simple control-register port. The read path is combinational. A write takes effect on the clock edge where it is presented.

The pins do not follow the register directly. A bus-access strobe samples the register, and that sample sets the pin levels used for that access. An access made with both lock bits set arms an automatic release, so the next access runs with both pins negated.

An exception-entry strobe moves each set lock bit into its shadow bit and clears the lock bit. Any bus access from then on runs unlocked. Hardware never clears a shadow bit, so nested exceptions keep the saved state, and software restores the lock bits before returning. A data-cache bypass flag marks every access made with the lock pin asserted.

Top module: `busLockTop`

## Requirements
- R1: Reset clears the whole register. It also drives both pins and the bypass flag low.
- R2: Register bit 31 is the lock bit, bit 30 the shadow lock bit, bit 29 the lock-end bit and bit 28 the shadow lock-end bit. A software write loads these four bits from the write data. Bits 27:0 always read as zero.
- R3: On a bus-access strobe, the lock pin takes the value of the lock bit and the lock-end pin takes the value of the lock-end bit. The pins are registered and change on that same clock edge.
- R4: The pins change only on a bus-access strobe. Register writes and exception strobes without an access leave them unchanged.
- R5: After an access made with both lock bits set, the next access drives both pins low whatever the register holds. If both bits are still set, the access after that asserts both pins again.
- R6: On an exception strobe, a set lock bit sets the shadow lock bit and is then cleared. The lock-end pair behaves the same way. A shadow bit is never cleared by an exception, including a nested one with the lock bit already clear.
- R7: A bus access in the same cycle as an exception strobe counts as exception processing and drives both pins low.
- R8: An exception strobe takes priority over a software write in the same cycle, and that write is discarded.
- R9: The data-cache bypass flag is high exactly while the lock pin is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Software write strobe for the register |
| regWrData | input | 32 | Software write data |
| regRdData | output | 32 | Register read data (combinational) |
| busStrobe | input | 1 | One cycle per bus access; samples the lock bits |
| excStrobe | input | 1 | One cycle at exception entry |
| lockPin | output | 1 | Bus lock pin, active high |
| lockEndPin | output | 1 | Bus lock-end pin, active high |
| bypassCache | output | 1 | Current access bypasses the data cache |

## Verification
A write or an exception strobe presented before a rising edge shows up on the read data right after that edge. A bus strobe updates the pins and the bypass flag on the same edge. The bench drives every input at the falling edge and checks all outputs at the next falling edge, which is one full edge after the stimulus.

The release that follows an access with both bits set becomes visible one access later. The vector table therefore sends runs of back-to-back strobes and checks the pins after each one.

// File: rtl/busLockPkg.sv
package busLockPkg;
  typedef struct packed {
    logic wrAccept;     // software write is applied this cycle
    logic excSave;      // exception entry: move lock bits to shadow
    logic busSample;    // bus access: update pins
    logic forceRelease; // this access must run with both pins low
  } lockStrobes_t;
endpackage

// File: rtl/busLockCtrl.sv
module busLockCtrl
  import busLockPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         busStrobe,
  input  logic         excStrobe,
  input  logic         lockBit,
  input  logic         lockEndBit,
  output lockStrobes_t strobes
);
  // Set after an access made with both lock bits set.
  logic releasePending;

  always_comb begin
    strobes.excSave      = excStrobe;
    strobes.wrAccept     = regWrEn & ~excStrobe;
    strobes.busSample    = busStrobe;
    strobes.forceRelease = busStrobe & (releasePending | excStrobe);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      releasePending <= 1'b0;
    end else if (busStrobe) begin
      if (strobes.forceRelease) releasePending <= 1'b0;
      else                      releasePending <= lockBit & lockEndBit;
    end
  end
endmodule

// File: rtl/busLockRegs.sv
module busLockRegs
  import busLockPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  lockStrobes_t     strobes,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             lockBit,
  output logic             lockEndBit,
  output logic             lockPinQ,
  output logic             lockEndPinQ
);
  localparam int L_POS   = REG_W - 1;
  localparam int SL_POS  = REG_W - 2;
  localparam int LE_POS  = REG_W - 3;
  localparam int SLE_POS = REG_W - 4;

  logic shadowLock, shadowLockEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBit       <= 1'b0;
      shadowLock    <= 1'b0;
      lockEndBit    <= 1'b0;
      shadowLockEnd <= 1'b0;
    end else if (strobes.excSave) begin
      if (lockBit)    shadowLock    <= 1'b1;
      if (lockEndBit) shadowLockEnd <= 1'b1;
      lockBit    <= 1'b0;
      lockEndBit <= 1'b0;
    end else if (strobes.wrAccept) begin
      lockBit       <= wrData[L_POS];
      shadowLock    <= wrData[SL_POS];
      lockEndBit    <= wrData[LE_POS];
      shadowLockEnd <= wrData[SLE_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockPinQ    <= 1'b0;
      lockEndPinQ <= 1'b0;
    end else if (strobes.busSample) begin
      lockPinQ    <= lockBit & ~strobes.forceRelease;
      lockEndPinQ <= lockEndBit & ~strobes.forceRelease;
    end
  end

  always_comb begin
    rdData          = '0;
    rdData[L_POS]   = lockBit;
    rdData[SL_POS]  = shadowLock;
    rdData[LE_POS]  = lockEndBit;
    rdData[SLE_POS] = shadowLockEnd;
  end
endmodule

// File: rtl/busLockTop.sv
module busLockTop
  import busLockPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             busStrobe,
  input  logic             excStrobe,
  output logic             lockPin,
  output logic             lockEndPin,
  output logic             bypassCache
);
  lockStrobes_t strobes;
  logic lockBit, lockEndBit;

  busLockCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .busStrobe  (busStrobe),
    .excStrobe  (excStrobe),
    .lockBit    (lockBit),
    .lockEndBit (lockEndBit),
    .strobes    (strobes)
  );

  busLockRegs #(.REG_W(REG_W)) i_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (regWrData),
    .rdData      (regRdData),
    .lockBit     (lockBit),
    .lockEndBit  (lockEndBit),
    .lockPinQ    (lockPin),
    .lockEndPinQ (lockEndPin)
  );

  // Locked operand accesses skip the data cache.
  assign bypassCache = lockPin;
endmodule

// File: rtl/busLockChecker.sv
module busLockChecker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regRdData,
  input logic             busStrobe,
  input logic             excStrobe,
  input logic             lockPin,
  input logic             lockEndPin
);
  // R4: pins hold between accesses
  a_r4_pins_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobe |=> $stable(lockPin) && $stable(lockEndPin));

  // R5: an access made with both pins asserted is followed by a released access
  a_r5_auto_release: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && lockPin && lockEndPin |=> !lockPin && !lockEndPin);

  // R7: access during exception entry runs unlocked
  a_r7_exc_access_low: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && excStrobe |=> !lockPin && !lockEndPin);

  // R6: a set lock bit moves into its shadow bit
  a_r6_shadow_save: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe && regRdData[REG_W-1] |=> regRdData[REG_W-2] && !regRdData[REG_W-1]);

  // R6: only a software write can clear the shadow lock bit
  a_r6_shadow_kept: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-2] && !(regWrEn && !excStrobe) |=> regRdData[REG_W-2]);

  // R8: an exception discards a same-cycle write and leaves both lock bits clear
  a_r8_exc_wins: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |=> !regRdData[REG_W-1] && !regRdData[REG_W-3]);
endmodule

bind busLockTop busLockChecker #(.REG_W(REG_W)) i_busLockChecker (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regRdData  (regRdData),
  .busStrobe  (busStrobe),
  .excStrobe  (excStrobe),
  .lockPin    (lockPin),
  .lockEndPin (lockEndPin)
);

// File: tb/test_busLockTop.sv
module test_busLockTop;
  logic clk = 1'b0;
  logic rstN;
  logic regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic busStrobe, excStrobe;
  logic lockPin, lockEndPin, bypassCache;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  busLockTop i_busLockTop (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .busStrobe(busStrobe), .excStrobe(excStrobe),
    .lockPin(lockPin), .lockEndPin(lockEndPin), .bypassCache(bypassCache)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Row: wr, wrNib{L,SL,LE,SLE}, bus, exc, expNib, expLock, expLockEnd
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 4'b1010, 1'b0, 1'b0, 4'b1010, 1'b0, 1'b0}, // write L,LE
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b1010, 1'b1, 1'b1}, // access locked
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b1010, 1'b0, 1'b0}, // auto release
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b1010, 1'b1, 1'b1}, // reassert
    {1'b1, 4'b1000, 1'b0, 1'b0, 4'b1000, 1'b1, 1'b1}, // write, pins hold
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b1000, 1'b0, 1'b0}, // release after both-set access
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b1000, 1'b1, 1'b0}, // L only
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b1000, 1'b1, 1'b0}, // no release for L only
    {1'b0, 4'b0000, 1'b0, 1'b1, 4'b0100, 1'b1, 1'b0}, // exception, pins hold
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b0100, 1'b0, 1'b0}, // exception access unlocked
    {1'b0, 4'b0000, 1'b0, 1'b1, 4'b0100, 1'b0, 1'b0}, // nested: shadow kept
    {1'b1, 4'b1110, 1'b0, 1'b1, 4'b0100, 1'b0, 1'b0}, // write lost to exception
    {1'b1, 4'b1110, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b0}, // restore
    {1'b0, 4'b0000, 1'b1, 1'b1, 4'b0101, 1'b0, 1'b0}, // access + exception
    {1'b1, 4'b1010, 1'b0, 1'b0, 4'b1010, 1'b0, 1'b0}, // software clears shadows
    {1'b1, 4'b0000, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1}, // access samples old bits
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0}, // release
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0}, // stays low
    {1'b1, 4'b0010, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0}, // LE only
    {1'b0, 4'b0000, 1'b1, 1'b0, 4'b0010, 1'b0, 1'b1}  // lock-end pin alone
  };

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; busStrobe = 1'b0; excStrobe = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 regRd", regRdData, 32'h0);
    check("R1 lockPin", {31'b0, lockPin}, 32'h0);
    check("R1 lockEndPin", {31'b0, lockEndPin}, 32'h0);
    check("R1 bypass", {31'b0, bypassCache}, 32'h0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      regWrEn   = VEC[i][12];
      regWrData = {VEC[i][11:8], 28'hFFFFFFF};
      busStrobe = VEC[i][7];
      excStrobe = VEC[i][6];
      @(negedge clk);
      regWrEn = 1'b0; busStrobe = 1'b0; excStrobe = 1'b0;
      check($sformatf("R2 R6 R8 regRd row %0d", i), regRdData, {VEC[i][5:2], 28'h0});
      check($sformatf("R3 R4 R5 R7 lockPin row %0d", i), {31'b0, lockPin}, {31'b0, VEC[i][1]});
      check($sformatf("R3 R4 R5 R7 lockEndPin row %0d", i), {31'b0, lockEndPin}, {31'b0, VEC[i][0]});
      check($sformatf("R9 bypass row %0d", i), {31'b0, bypassCache}, {31'b0, VEC[i][1]});
    end
    // R1: reset from a locked state
    regWrEn = 1'b1; regWrData = 32'hF000_0000; @(negedge clk);
    regWrEn = 1'b0; busStrobe = 1'b1; @(negedge clk);
    busStrobe = 1'b0;
    check("R3 lockPin before reset", {31'b0, lockPin}, 32'h1);
    rstN = 1'b0; @(negedge clk);
    check("R1 regRd after reset", regRdData, 32'h0);
    check("R1 lockPin after reset", {31'b0, lockPin}, 32'h0);
    check("R1 lockEndPin after reset", {31'b0, lockEndPin}, 32'h0);
    rstN = 1'b1;
    // R5: release is not pending after reset
    regWrEn = 1'b1; regWrData = 32'hA000_0000; @(negedge clk);
    regWrEn = 1'b0; busStrobe = 1'b1; @(negedge clk);
    busStrobe = 1'b0;
    check("R5 first access after reset locks", {30'b0, lockPin, lockEndPin}, 32'h3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule